// File: doc/BRIEF.md
# Accumulator and Link Arithmetic Unit

This block holds a 12-bit accumulator together with a single link bit that acts as its thirteenth, upper extension. A controller presents an operation code, a 12-bit memory operand and a one-cycle strobe. On a strobed cycle the block clears, complements or increments the accumulator, adds the operand in two's complement, rotates or shifts the accumulator, sets or clears the link alone, or compares the accumulator against the operand. When no strobe is present, all state holds.

Bit numbering in the accumulator runs from the most significant end. Bit 0 is the MSB and corresponds to vector index 11. The link behaves as an overflow toggle rather than a carry flag: a carry out of the MSB inverts it. For every rotate and shift, a separate input selects whether the link joins the accumulator in a 13-bit loop or stays outside a 12-bit loop. A compare leaves the accumulator and the link untouched. Its result appears as a flag that is high for exactly the one cycle after the strobe.

Top module: `acc_link_unit`

## Requirements
- R1: A synchronous reset sets the accumulator to 0, the link to 0 and the compare flag to 0.
- R2: Without a strobe, the accumulator and the link hold their values. The same holds on a strobe with opcode 0 or with opcodes 13 to 15.
- R3: Opcode 1 clears the accumulator and opcode 2 inverts every accumulator bit. Neither operation changes the link.
- R4: Opcode 3 adds one to the accumulator. When the accumulator wraps from 7777 octal to 0, the link is inverted; otherwise the link is kept.
- R5: Opcode 4 loads the accumulator with the low 12 bits of accumulator plus operand. A carry out of the MSB inverts the link and never forces it to 1.
- R6: Opcode 5 clears the link and opcode 6 sets it. The accumulator is not changed by either.
- R7: Opcodes 7 (rotate left) and 8 (rotate right) with useLink=0 rotate the 12-bit accumulator and keep the link.
- R8: Opcodes 7 and 8 with useLink=1 rotate the 13-bit word {link, accumulator}. A left rotate moves the MSB into the link and the link into the LSB. A right rotate moves the link into the MSB and the LSB into the link.
- R9: Opcodes 9 (shift left) and 10 (shift right) with useLink=0 shift the accumulator and fill the vacated bit with 0, keeping the link.
- R10: Opcodes 9 and 10 with useLink=1 shift the 13-bit word {link, accumulator} and fill the vacated end with 0. A left shift moves the MSB into the link. A right shift moves the link into the MSB and clears the link.
- R11: Opcode 11 is a logical compare. The flag is 1 in the cycle after the strobe when the accumulator equals the operand bit for bit, and the accumulator and link are unchanged.
- R12: Opcode 12 is an arithmetic compare. The flag is 1 in the cycle after the strobe when the signed accumulator is less than the signed operand, and the state is unchanged. In every other cycle the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Apply the operation this cycle |
| opCode | input | 4 | Operation select |
| useLink | input | 1 | Include the link in a rotate or shift |
| operand | input | 12 | Memory operand |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| cmpFlag | output | 1 | Compare result, valid for one cycle |

## Verification
The bench builds the unit with its default width of 12 bits, so the boundary values sit at 7777 and 4000 octal. At that width the bench can reach the increment wrap, a carry while the link is already set (where a toggle and a set give different results), and a signed compare across the sign boundary with operands of opposite sign. It also brings out the bit that leaves and enters each end of the 12-bit and 13-bit loops.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_CMP  = 4'd2,
    OP_INC  = 4'd3,
    OP_ADD  = 4'd4,
    OP_LCLR = 4'd5,
    OP_LSET = 4'd6,
    OP_ROTL = 4'd7,
    OP_ROTR = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_EQL  = 4'd11,
    OP_LTS  = 4'd12
  } aluOp_t;

  typedef struct packed {
    logic clrAcc;
    logic invAcc;
    logic incAcc;
    logic addAcc;
    logic clrLink;
    logic setLink;
    logic rotate;
    logic shift;
    logic left;
    logic thruLink;
    logic cmpLog;
    logic cmpArith;
  } ctlStrobes_t;

endpackage

// File: rtl/acc_link_ctrl.sv
module acc_link_ctrl
  import acc_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strobe,
  input  logic [3:0]  opCode,
  input  logic        useLink,
  output ctlStrobes_t ctl
);

  always_comb begin
    ctl = '0;
    if (strobe) begin
      unique case (opCode)
        OP_CLR:  ctl.clrAcc = 1'b1;
        OP_CMP:  ctl.invAcc = 1'b1;
        OP_INC:  ctl.incAcc = 1'b1;
        OP_ADD:  ctl.addAcc = 1'b1;
        OP_LCLR: ctl.clrLink = 1'b1;
        OP_LSET: ctl.setLink = 1'b1;
        OP_ROTL: begin ctl.rotate = 1'b1; ctl.left = 1'b1; ctl.thruLink = useLink; end
        OP_ROTR: begin ctl.rotate = 1'b1; ctl.thruLink = useLink; end
        OP_SHL:  begin ctl.shift = 1'b1; ctl.left = 1'b1; ctl.thruLink = useLink; end
        OP_SHR:  begin ctl.shift = 1'b1; ctl.thruLink = useLink; end
        OP_EQL:  ctl.cmpLog = 1'b1;
        OP_LTS:  ctl.cmpArith = 1'b1;
        default: ctl = '0;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.clrAcc, ctl.invAcc, ctl.incAcc, ctl.addAcc, ctl.clrLink,
              ctl.setLink, ctl.rotate, ctl.shift, ctl.cmpLog, ctl.cmpArith})); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (ctl == '0)); // R2

endmodule

// File: rtl/acc_link_datapath.sv
module acc_link_datapath
  import acc_link_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] accQ,
  output logic              linkQ,
  output logic              flagQ
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sumW;
  logic [DATA_W:0]   incW;
  logic [DATA_W-1:0] accNext;
  logic              linkNext;
  logic              flagNext;

  assign sumW = {1'b0, accQ} + {1'b0, opnd};
  assign incW = {1'b0, accQ} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    accNext  = accQ;
    linkNext = linkQ;
    if (ctl.clrAcc) accNext = '0;
    if (ctl.invAcc) accNext = ~accQ;
    if (ctl.incAcc) begin
      accNext  = incW[MSB:0];
      linkNext = linkQ ^ incW[DATA_W];
    end
    if (ctl.addAcc) begin
      accNext  = sumW[MSB:0];
      linkNext = linkQ ^ sumW[DATA_W];
    end
    if (ctl.clrLink) linkNext = 1'b0;
    if (ctl.setLink) linkNext = 1'b1;
    if (ctl.rotate) begin
      if (ctl.left) begin
        if (ctl.thruLink) begin
          accNext  = {accQ[MSB-1:0], linkQ};
          linkNext = accQ[MSB];
        end else begin
          accNext = {accQ[MSB-1:0], accQ[MSB]};
        end
      end else begin
        if (ctl.thruLink) begin
          accNext  = {linkQ, accQ[MSB:1]};
          linkNext = accQ[0];
        end else begin
          accNext = {accQ[0], accQ[MSB:1]};
        end
      end
    end
    if (ctl.shift) begin
      if (ctl.left) begin
        accNext = {accQ[MSB-1:0], 1'b0};
        if (ctl.thruLink) linkNext = accQ[MSB];
      end else begin
        if (ctl.thruLink) begin
          accNext  = {linkQ, accQ[MSB:1]};
          linkNext = 1'b0;
        end else begin
          accNext = {1'b0, accQ[MSB:1]};
        end
      end
    end
  end

  always_comb begin
    flagNext = 1'b0;
    if (ctl.cmpLog)   flagNext = (accQ == opnd);
    if (ctl.cmpArith) flagNext = ($signed(accQ) < $signed(opnd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      linkQ <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      accQ  <= accNext;
      linkQ <= linkNext;
      flagQ <= flagNext;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ctl == '0) |=> ($stable(accQ) && $stable(linkQ))); // R2

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    ctl.incAcc |=> ((accQ == '0) == (linkQ != $past(linkQ)))); // R4

  AST_ADD_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ctl.addAcc |=> ((accQ < $past(accQ)) == (linkQ != $past(linkQ)))); // R5

  AST_LINK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctl.clrLink || ctl.setLink) |=> ($stable(accQ) && (linkQ == $past(ctl.setLink)))); // R6

  AST_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ctl.cmpLog || ctl.cmpArith) |=> ($stable(accQ) && $stable(linkQ))); // R11

  AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (rst)
    flagQ |-> $past(ctl.cmpLog || ctl.cmpArith)); // R12

endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acc_link_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [3:0]        opCode,
  input  logic              useLink,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              link,
  output logic              cmpFlag
);

  ctlStrobes_t ctl;

  acc_link_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opCode  (opCode),
    .useLink (useLink),
    .ctl     (ctl)
  );

  acc_link_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .opnd  (operand),
    .accQ  (acc),
    .linkQ (link),
    .flagQ (cmpFlag)
  );

endmodule

// File: tb/acc_link_unit_test.sv
`timescale 1ns/1ps
module acc_link_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        useLink = 1'b0;
  logic [11:0] operand = '0;
  logic [11:0] acc;
  logic        link;
  logic        cmpFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_link_unit uut (
    .clk(clk), .rst(rst), .strobe(strobe), .opCode(opCode),
    .useLink(useLink), .operand(operand), .acc(acc), .link(link),
    .cmpFlag(cmpFlag)
  );

  task automatic check(string req, logic [11:0] expAcc, logic expLink, logic expFlag);
    checks++;
    if (acc !== expAcc || link !== expLink || cmpFlag !== expFlag) begin
      fails++;
      $display("FAIL %s: acc=%o link=%b flag=%b expected acc=%o link=%b flag=%b",
               req, acc, link, cmpFlag, expAcc, expLink, expFlag);
    end
  endtask

  // One strobed operation; outputs are sampled at the following negedge.
  task automatic doOp(logic [3:0] op, logic withL, logic [11:0] opnd);
    @(negedge clk);
    opCode = op; useLink = withL; operand = opnd; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  // Load the accumulator and link to a known state.
  task automatic preset(logic [11:0] val, logic l);
    doOp(4'd1, 1'b0, '0);
    doOp(4'd4, 1'b0, val);
    doOp(l ? 4'd6 : 4'd5, 1'b0, '0);
  endtask

  task automatic testReset();
    check("R1 reset", 12'o0000, 1'b0, 1'b0);
  endtask

  task automatic testHold();
    preset(12'o1234, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R2 no strobe", 12'o1234, 1'b1, 1'b0);
    doOp(4'd0, 1'b1, 12'o7777);
    check("R2 opcode 0", 12'o1234, 1'b1, 1'b0);
    doOp(4'd14, 1'b0, 12'o7777);
    check("R2 opcode 14", 12'o1234, 1'b1, 1'b0);
  endtask

  task automatic testClrCmp();
    preset(12'o1234, 1'b1);
    doOp(4'd2, 1'b0, '0);
    check("R3 complement", 12'o6543, 1'b1, 1'b0);
    doOp(4'd1, 1'b0, '0);
    check("R3 clear", 12'o0000, 1'b1, 1'b0);
  endtask

  task automatic testInc();
    preset(12'o0017, 1'b0);
    doOp(4'd3, 1'b0, '0);
    check("R4 increment", 12'o0020, 1'b0, 1'b0);
    preset(12'o7777, 1'b0);
    doOp(4'd3, 1'b0, '0);
    check("R4 wrap toggles 0->1", 12'o0000, 1'b1, 1'b0);
    preset(12'o7777, 1'b1);
    doOp(4'd3, 1'b0, '0);
    check("R4 wrap toggles 1->0", 12'o0000, 1'b0, 1'b0);
  endtask

  task automatic testAdd();
    preset(12'o0100, 1'b0);
    doOp(4'd4, 1'b0, 12'o0023);
    check("R5 add no carry", 12'o0123, 1'b0, 1'b0);
    preset(12'o7000, 1'b0);
    doOp(4'd4, 1'b0, 12'o2000);
    check("R5 carry sets clear link", 12'o1000, 1'b1, 1'b0);
    preset(12'o7000, 1'b1);
    doOp(4'd4, 1'b0, 12'o2000);
    check("R5 carry clears set link", 12'o1000, 1'b0, 1'b0);
  endtask

  task automatic testLink();
    preset(12'o4321, 1'b0);
    doOp(4'd6, 1'b0, 12'o7777);
    check("R6 set link", 12'o4321, 1'b1, 1'b0);
    doOp(4'd5, 1'b0, 12'o7777);
    check("R6 clear link", 12'o4321, 1'b0, 1'b0);
  endtask

  task automatic testRot12();
    preset(12'o4001, 1'b0);
    doOp(4'd7, 1'b0, '0);
    check("R7 rotate left 12", 12'o0003, 1'b0, 1'b0);
    preset(12'o4001, 1'b1);
    doOp(4'd8, 1'b0, '0);
    check("R7 rotate right 12", 12'o6000, 1'b1, 1'b0);
  endtask

  task automatic testRot13();
    preset(12'o4000, 1'b0);
    doOp(4'd7, 1'b1, '0);
    check("R8 rotate left 13", 12'o0000, 1'b1, 1'b0);
    doOp(4'd7, 1'b1, '0);
    check("R8 rotate left 13 second", 12'o0001, 1'b0, 1'b0);
    preset(12'o0001, 1'b1);
    doOp(4'd8, 1'b1, '0);
    check("R8 rotate right 13", 12'o4000, 1'b1, 1'b0);
  endtask

  task automatic testShift12();
    preset(12'o4001, 1'b1);
    doOp(4'd9, 1'b0, '0);
    check("R9 shift left 12", 12'o0002, 1'b1, 1'b0);
    preset(12'o4001, 1'b1);
    doOp(4'd10, 1'b0, '0);
    check("R9 shift right 12", 12'o2000, 1'b1, 1'b0);
  endtask

  task automatic testShift13();
    preset(12'o4001, 1'b0);
    doOp(4'd9, 1'b1, '0);
    check("R10 shift left 13", 12'o0002, 1'b1, 1'b0);
    preset(12'o0003, 1'b1);
    doOp(4'd10, 1'b1, '0);
    check("R10 shift right 13", 12'o4001, 1'b0, 1'b0);
  endtask

  task automatic testLogCmp();
    preset(12'o5252, 1'b1);
    doOp(4'd11, 1'b0, 12'o5252);
    check("R11 equal flag", 12'o5252, 1'b1, 1'b1);
    @(negedge clk);
    check("R11 flag one cycle", 12'o5252, 1'b1, 1'b0);
    doOp(4'd11, 1'b0, 12'o5253);
    check("R11 unequal", 12'o5252, 1'b1, 1'b0);
  endtask

  task automatic testArithCmp();
    preset(12'o7777, 1'b0);
    doOp(4'd12, 1'b0, 12'o0001);
    check("R12 -1 < 1", 12'o7777, 1'b0, 1'b1);
    preset(12'o0001, 1'b0);
    doOp(4'd12, 1'b0, 12'o7777);
    check("R12 1 not < -1", 12'o0001, 1'b0, 1'b0);
    preset(12'o4000, 1'b1);
    doOp(4'd12, 1'b0, 12'o3777);
    check("R12 min < max", 12'o4000, 1'b1, 1'b1);
    @(negedge clk);
    check("R12 flag drops", 12'o4000, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testHold();
    testClrCmp();
    testInc();
    testAdd();
    testLink();
    testRot12();
    testRot13();
    testShift12();
    testShift13();
    testLogCmp();
    testArithCmp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule